// File: doc/BRIEF.md
# Program Memory Byte Reader

This unit fetches one byte at a time from a program memory that is organised in 16-bit words. It serves a small 8-bit processor core. The requester supplies a 16-bit byte pointer, an 8-bit page value and a two-bit command. The unit splits the pointer into a word address and a lane select, and it can place the page value above the word address. It issues a single read to a synchronous memory with one cycle of latency. It then returns the selected byte together with the pointer and page values that belong in the register file afterwards.

The command has two bits. Bit 0 requests post-increment, which adds one to the whole byte pointer. Bit 1 requests extended addressing, which uses the page value as the upper word-address bits. When both bits are set and the increment carries out of the 16-bit pointer, the page value also advances. The unit accepts one request at a time and holds `req_ready` low until the current response has been delivered.

Top module: `pm_byte_reader`

## Requirements
- R1: The memory word address is the pointer with its least significant bit dropped (pointer bits 15..1 on `mem_addr[14:0]`). With command bit 1 set, the page value occupies `mem_addr[22:15]`.
- R2: Pointer bit 0 = 0 returns `mem_rdata[7:0]` on `rsp_byte`. Pointer bit 0 = 1 returns `mem_rdata[15:8]`.
- R3: With command bit 1 clear, the page input has no effect on the access: `mem_addr[22:15]` is zero.
- R4: With command bit 0 set, `rsp_ptr` is the request pointer plus one and `rsp_wb` is 1. With command bit 0 clear, `rsp_ptr` equals the request pointer and `rsp_wb` is 0.
- R5: With command 2'b11 and pointer 16'hFFFF, `rsp_ptr` becomes 0 and `rsp_page` is the page plus one, wrapping 8'hFF to 8'h00. In every other case `rsp_page` equals the request page, including command 2'b01 with pointer 16'hFFFF.
- R6: A request accepted at a clock edge (`req_valid` and `req_ready` both high) raises `mem_en` for exactly the next cycle. `rsp_done` follows as a single-cycle pulse in the cycle after that.
- R7: `req_ready` is low from acceptance through the `rsp_done` cycle. A request held while busy is not taken, and it causes no additional memory read.
- R8: After reset, `req_ready` is 1 and both `rsp_done` and `mem_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 2 | Bit 0 post-increment, bit 1 extended page |
| req_ptr | input | 16 | Byte pointer |
| req_page | input | 8 | Page value for extended reads |
| req_ready | output | 1 | Unit idle, request will be taken |
| mem_en | output | 1 | Memory read enable |
| mem_addr | output | 23 | Memory word address |
| mem_rdata | input | 16 | Memory word, valid the cycle after `mem_en` |
| rsp_done | output | 1 | Response strobe |
| rsp_byte | output | 8 | Selected byte |
| rsp_ptr | output | 16 | Pointer to write back |
| rsp_page | output | 8 | Page to write back |
| rsp_wb | output | 1 | Pointer/page write-back requested |

## Verification
The assertions assume that the memory presents the addressed word on `mem_rdata` in the cycle after `mem_en` and holds it until its next read. The bench memory model is built to do exactly that. They also assume that `req_cmd`, `req_ptr` and `req_page` are stable while `req_valid` is high. The driver changes them only on the falling edge, and only after the previous request has been taken. Every command code is sent, with both pointer parities and at the pointer and page extremes. Requests are issued back to back, so each one waits on `req_ready` while the unit is still busy.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
    localparam int PTR_W   = 16;
    localparam int PAGE_W  = 8;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 2;
    localparam int LSEL_W  = $clog2(LANES);
    localparam int WORD_W  = BYTE_W * LANES;
    localparam int WADDR_W = PTR_W - LSEL_W + PAGE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } pmr_state_e;

    typedef struct packed {
        logic              ext;
        logic              inc;
        logic [PTR_W-1:0]  ptr;
        logic [PAGE_W-1:0] page;
    } pmr_req_t;

    function automatic pmr_req_t pmr_decode(input logic [1:0] cmd,
                                            input logic [PTR_W-1:0] ptr,
                                            input logic [PAGE_W-1:0] page);
        pmr_req_t r;
        r.inc  = cmd[0];
        r.ext  = cmd[1];
        r.ptr  = ptr;
        r.page = page;
        return r;
    endfunction
endpackage

// File: rtl/pmr_addr_map.sv
module pmr_addr_map #(
    parameter int PTR_W  = 16,
    parameter int PAGE_W = 8,
    parameter int LSEL_W = 1,
    parameter int WADDR_W = PTR_W - LSEL_W + PAGE_W
) (
    input  logic               ext,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [PAGE_W-1:0]  page,
    output logic [WADDR_W-1:0] waddr
);
    logic [PAGE_W-1:0] hi;
    always_comb begin
        hi    = ext ? page : '0;
        waddr = {hi, ptr[PTR_W-1:LSEL_W]};
    end
endmodule

// File: rtl/pmr_ptr_next.sv
module pmr_ptr_next #(
    parameter int PTR_W  = 16,
    parameter int PAGE_W = 8
) (
    input  logic              inc,
    input  logic              ext,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [PAGE_W-1:0] page,
    output logic [PTR_W-1:0]  nptr,
    output logic [PAGE_W-1:0] npage
);
    logic carry;
    always_comb begin
        {carry, nptr} = {1'b0, ptr} + {{PTR_W{1'b0}}, inc};
        npage = (ext && carry) ? page + PAGE_W'(1) : page;
    end
endmodule

// File: rtl/pmr_lane_pick.sv
module pmr_lane_pick #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    parameter int SEL_W  = $clog2(LANES)
) (
    input  logic [BYTE_W*LANES-1:0] word,
    input  logic [SEL_W-1:0]        sel,
    output logic [BYTE_W-1:0]       lane_byte
);
    logic [BYTE_W-1:0] lane [LANES];
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word[g*BYTE_W +: BYTE_W];
    end
    assign lane_byte = lane[sel];
endmodule

// File: rtl/pm_byte_reader.sv
module pm_byte_reader
    import pmr_pkg::*;
#(
    parameter int P_PTR_W  = PTR_W,
    parameter int P_PAGE_W = PAGE_W,
    parameter int P_BYTE_W = BYTE_W,
    localparam int P_WORD_W  = P_BYTE_W * LANES,
    localparam int P_WADDR_W = P_PTR_W - LSEL_W + P_PAGE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [1:0]           req_cmd,
    input  logic [P_PTR_W-1:0]   req_ptr,
    input  logic [P_PAGE_W-1:0]  req_page,
    output logic                 req_ready,
    output logic                 mem_en,
    output logic [P_WADDR_W-1:0] mem_addr,
    input  logic [P_WORD_W-1:0]  mem_rdata,
    output logic                 rsp_done,
    output logic [P_BYTE_W-1:0]  rsp_byte,
    output logic [P_PTR_W-1:0]   rsp_ptr,
    output logic [P_PAGE_W-1:0]  rsp_page,
    output logic                 rsp_wb
);
    pmr_state_e state;
    pmr_req_t   cur;
    logic       accept;

    assign accept    = req_valid && req_ready;
    assign req_ready = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    cur   <= pmr_decode(req_cmd, req_ptr, req_page);
                    state <= ST_FETCH;
                end
                ST_FETCH: state <= ST_RESP;
                ST_RESP:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    pmr_addr_map #(
        .PTR_W(P_PTR_W), .PAGE_W(P_PAGE_W), .LSEL_W(LSEL_W)
    ) u_map (
        .ext(cur.ext), .ptr(cur.ptr), .page(cur.page), .waddr(mem_addr)
    );

    pmr_ptr_next #(
        .PTR_W(P_PTR_W), .PAGE_W(P_PAGE_W)
    ) u_next (
        .inc(cur.inc), .ext(cur.ext), .ptr(cur.ptr), .page(cur.page),
        .nptr(rsp_ptr), .npage(rsp_page)
    );

    pmr_lane_pick #(
        .BYTE_W(P_BYTE_W), .LANES(LANES)
    ) u_lane (
        .word(mem_rdata), .sel(cur.ptr[LSEL_W-1:0]), .lane_byte(rsp_byte)
    );

    assign mem_en   = (state == ST_FETCH);
    assign rsp_done = (state == ST_RESP);
    assign rsp_wb   = rsp_done && cur.inc;
endmodule

// File: rtl/pmr_checker.sv
module pmr_checker #(
    parameter int PTR_W   = 16,
    parameter int PAGE_W  = 8,
    parameter int WADDR_W = 23
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [1:0]         req_cmd,
    input logic [PTR_W-1:0]   req_ptr,
    input logic               req_ready,
    input logic               mem_en,
    input logic [WADDR_W-1:0] mem_addr,
    input logic               rsp_done,
    input logic               rsp_wb
);
    localparam int LOW_W = PTR_W - 1;

    assert_reset_idle_R8: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_done && !mem_en));

    assert_accept_reads_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> mem_en);

    assert_read_then_done_R6: assert property (@(posedge clk) disable iff (rst)
        mem_en |=> (rsp_done && !mem_en));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    assert_busy_fetch_R7: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> !req_ready);

    assert_busy_resp_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> !req_ready);

    assert_word_addr_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (mem_addr[LOW_W-1:0] == $past(req_ptr[PTR_W-1:1])));

    assert_page_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_cmd[1]) |=> (mem_addr[WADDR_W-1:LOW_W] == '0));

    assert_wb_in_done_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_wb |-> rsp_done);
endmodule

bind pm_byte_reader pmr_checker #(
    .PTR_W(P_PTR_W), .PAGE_W(P_PAGE_W), .WADDR_W(P_WADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_ptr(req_ptr), .req_ready(req_ready), .mem_en(mem_en),
    .mem_addr(mem_addr), .rsp_done(rsp_done), .rsp_wb(rsp_wb)
);

// File: tb/sim_pm_byte_reader.sv
`timescale 1ns/1ps
module sim_pm_byte_reader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cmd = '0;
    logic [15:0] req_ptr = '0;
    logic [7:0]  req_page = '0;
    logic        req_ready, mem_en, rsp_done, rsp_wb;
    logic [22:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [7:0]  rsp_byte, rsp_page;
    logic [15:0] rsp_ptr;

    typedef struct {
        logic [22:0] addr;
        logic [7:0]  byte_v;
        logic [15:0] ptr;
        logic [7:0]  page;
        logic        wb;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails = 0;
    int issued = 0;
    int reads = 0;
    logic [22:0] seen_addr = '0;

    always #5 clk = ~clk;

    pm_byte_reader u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_ptr(req_ptr), .req_page(req_page), .req_ready(req_ready),
        .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .rsp_done(rsp_done), .rsp_byte(rsp_byte), .rsp_ptr(rsp_ptr),
        .rsp_page(rsp_page), .rsp_wb(rsp_wb)
    );

    function automatic logic [15:0] mem_word(input logic [22:0] a);
        return {a[7:0] ^ 8'h5A ^ a[22:15], a[14:7] + 8'h3C};
    endfunction

    // synchronous memory model: one cycle of read latency, output held
    always @(posedge clk) if (mem_en) mem_rdata <= mem_word(mem_addr);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] cmd, input logic [15:0] ptr, input logic [7:0] page);
        exp_t e;
        logic [7:0]  hi;
        logic [15:0] w;
        hi       = cmd[1] ? page : 8'h00;
        e.addr   = {hi, ptr[15:1]};
        w        = mem_word(e.addr);
        e.byte_v = ptr[0] ? w[15:8] : w[7:0];
        e.ptr    = cmd[0] ? ptr + 16'd1 : ptr;
        e.page   = (cmd == 2'b11 && ptr == 16'hFFFF) ? page + 8'd1 : page;
        e.wb     = cmd[0];
        exp_q.push_back(e);
        req_cmd = cmd; req_ptr = ptr; req_page = page; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        issued++;
        req_valid = 1'b0;
        chk("R7 ready low after accept", {31'd0, req_ready}, 32'd0);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_en) begin
                seen_addr = mem_addr;
                reads++;
            end
            if (rsp_done) begin
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected response", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk("R1/R3 word address", {9'd0, seen_addr}, {9'd0, e.addr});
                    chk("R2 selected byte", {24'd0, rsp_byte}, {24'd0, e.byte_v});
                    chk("R4 pointer out", {16'd0, rsp_ptr}, {16'd0, e.ptr});
                    chk("R5 page out", {24'd0, rsp_page}, {24'd0, e.page});
                    chk("R4 write-back flag", {31'd0, rsp_wb}, {31'd0, e.wb});
                end
            end
        end
    end

    bit finished = 0;
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R8 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R8 done low after reset", {31'd0, rsp_done}, 32'd0);
        chk("R8 mem_en low after reset", {31'd0, mem_en}, 32'd0);
        issue(2'b00, 16'h1234, 8'hAB);   // R2 low lane, R3 page ignored
        issue(2'b00, 16'h1235, 8'hCD);   // R2 high lane
        issue(2'b01, 16'h00FF, 8'h11);   // R4 post-increment
        issue(2'b10, 16'h8001, 8'h05);   // R1 extended address
        issue(2'b11, 16'hFFFF, 8'h07);   // R5 carry into page
        issue(2'b11, 16'hFFFF, 8'hFF);   // R5 page wraps
        issue(2'b01, 16'hFFFF, 8'h42);   // R5 no page carry when not extended
        issue(2'b10, 16'hFFFE, 8'hFF);   // R1 top of memory
        issue(2'b11, 16'h7FFE, 8'h80);   // R4 extended increment, no carry
        for (int i = 0; i < 8; i++)
            issue(2'(i), 16'h2468 + 16'(i * 777), 8'(i * 37));
        repeat (6) @(negedge clk);
        chk("R7 one read per request", reads, issued);
        chk("R6 all responses seen", exp_q.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule